// File: doc/BRIEF.md
# MDIO Management Master

This block lets software run clause-22 management transactions against external PHY devices. It sits on a plain 32-bit register bus with six word registers. Software programs the target PHY and register number, then writes the data word to start a write transaction, or toggles a command bit from 0 to 1 to start a read. While a transaction runs, the block drives the management clock from a programmable divider. It drives the data line or releases it as the phase of the frame requires.

Software polls an indication register to see when the line is busy and whether fresh read data is still pending. Read data lands in a status register. A soft-reset bit in the configuration register aborts whatever is on the wire and returns the engine to idle.

Register words are selected by `busAddr`: 0 configuration, 1 command, 2 address, 3 control-data, 4 status-data, 5 indication. Unused bits read as 0.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The address register (word 2) holds the PHY address in bits 12:8 and the register number in bits 4:0, and reads back exactly those fields.
- R2: Any bus write to the control-data register (word 3) while idle starts a write frame. The frame carries, MSB first on successive MDC rising edges: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the low 16 bits of the written word.
- R3: A read frame (opcode 10, otherwise the same header) starts only when command bit 0 is written 0→1. Writing 1 while the bit is already 1 starts nothing.
- R4: Indication bit 0 reads 1 from the cycle after a frame is started until the frame has ended.
- R5: Indication bit 2 reads 1 from the start of a read until the read data has been captured.
- R6: After a read, the 16 data bits sampled from the PHY read back in bits 15:0 of the status-data register (word 4) once both indication flags are clear.
- R7: Writing a configuration word with bit 31 set aborts any frame. On the next cycle both indication flags read 0 and MDIO is released.
- R8: Configuration bits 2:0 (N, reset value 7) set the MDC period to 2^(N+2) system clocks. MDC idles low.
- R9: During a read the master releases MDIO for the two turnaround bits and the 16 data bits, and samples the data on MDC rising edges.
- R10: While a frame runs, MDIO changes only together with a falling edge of MDC.
- R11: A control-data write or a command 0→1 edge that arrives while busy is ignored. The control-data register keeps its old value and the frame in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word select |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value driven to the line |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data value seen on the line |

## Verification
The assertions rely on the register bus presenting at most one write per cycle. They also rely on the configuration divider being steady for the length of a frame, which holds because the engine latches it at frame start. The stimulus changes the divider only while idle, except for the soft-reset write, whose effect the assertions allow for. The bench responder drives `mdioIn` only in the low half of MDC, so the sampled bits are stable around every rising edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DIV_W  = 3;
  localparam int PHY_W  = 5;
  localparam int RNUM_W = 5;
  localparam int DATA_W = 16;
  localparam int PRE_W  = 32;
  localparam int FRAME_W = PRE_W + 2 + 2 + PHY_W + RNUM_W + 2 + DATA_W;
  localparam int BUS_W  = 32;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_CFG  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IND  = 3'd5;

  typedef struct packed {
    logic              start;
    logic              isRead;
    logic              abort;
    logic [DIV_W-1:0]  div;
    logic [PHY_W-1:0]  phyAddr;
    logic [RNUM_W-1:0] regNum;
    logic [DATA_W-1:0] wrData;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [SEL_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output mdioStrobes_t      strb,
  input  logic              dpBusy,
  input  logic              rdDone,
  input  logic [DATA_W-1:0] rdData
);
  localparam logic [DIV_W-1:0] DIV_RESET = '1;
  localparam int SOFT_RST_BIT = BUS_W - 1;
  localparam int PHY_LSB = 8;

  logic [DIV_W-1:0]  divReg;
  logic              cmdBit;
  logic [PHY_W-1:0]  phyReg;
  logic [RNUM_W-1:0] regNumReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] statReg;
  logic              notValid;

  logic wrCfg, wrCmd, wrAddr, wrData, softRst, startWr, startRd;

  always_comb begin
    wrCfg   = busWrite && (busAddr == SEL_CFG);
    wrCmd   = busWrite && (busAddr == SEL_CMD);
    wrAddr  = busWrite && (busAddr == SEL_ADDR);
    wrData  = busWrite && (busAddr == SEL_DATA);
    softRst = wrCfg && busWdata[SOFT_RST_BIT];
    startWr = wrData && !dpBusy;
    startRd = wrCmd && busWdata[0] && !cmdBit && !dpBusy;
  end

  always_comb begin
    strb.start   = startWr || startRd;
    strb.isRead  = startRd;
    strb.abort   = softRst;
    strb.div     = divReg;
    strb.phyAddr = phyReg;
    strb.regNum  = regNumReg;
    strb.wrData  = busWdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg    <= DIV_RESET;
      cmdBit    <= 1'b0;
      phyReg    <= '0;
      regNumReg <= '0;
      dataReg   <= '0;
      statReg   <= '0;
      notValid  <= 1'b0;
    end else begin
      if (wrCfg)   divReg <= busWdata[DIV_W-1:0];
      if (wrCmd)   cmdBit <= busWdata[0];
      if (wrAddr) begin
        phyReg    <= busWdata[PHY_LSB +: PHY_W];
        regNumReg <= busWdata[RNUM_W-1:0];
      end
      if (startWr) dataReg <= busWdata[DATA_W-1:0];
      if (rdDone)  statReg <= rdData;
      if (softRst)      notValid <= 1'b0;
      else if (startRd) notValid <= 1'b1;
      else if (rdDone)  notValid <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      SEL_CFG:  busRdata[DIV_W-1:0] = divReg;
      SEL_CMD:  busRdata[0] = cmdBit;
      SEL_ADDR: begin
        busRdata[PHY_LSB +: PHY_W] = phyReg;
        busRdata[RNUM_W-1:0]       = regNumReg;
      end
      SEL_DATA: busRdata[DATA_W-1:0] = dataReg;
      SEL_STAT: busRdata[DATA_W-1:0] = statReg;
      SEL_IND: begin
        busRdata[0] = dpBusy;
        busRdata[2] = notValid;
      end
      default:  busRdata = '0;
    endcase
  end

  a_r5_notvalid_on_read: assert property (@(posedge clk) disable iff (!rstN)
    startRd |=> notValid);
  a_r6_capture_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && !softRst) |=> (!notValid && statReg == $past(rdData)));
  a_r11_data_kept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && dpBusy) |=> $stable(dataReg));
  a_r7_soft_clears_nv: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !notValid);
endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobes_t      strb,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              busy,
  output logic              rdDone,
  output logic [DATA_W-1:0] rdData
);
  localparam int CNT_W    = (1 << DIV_W) + 2;
  localparam int BIT_W    = $clog2(FRAME_W);
  localparam int DATA_POS = FRAME_W - DATA_W;
  localparam int TA_POS   = DATA_POS - 2;
  localparam int SH_W     = DIV_W + 1;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lowMask, fullMask;
  logic [FRAME_W-1:0] txShift, frame;
  logic [BIT_W-1:0]   bitIdx;
  logic [DIV_W-1:0]   divQ;
  logic [DATA_W-1:0]  rxShift;
  logic               busyQ, readQ;
  logic               riseTick, fallTick, lastBit;

  always_comb begin
    lowMask  = (CNT_W'(1) << (SH_W'(divQ) + SH_W'(1))) - CNT_W'(1);
    fullMask = (CNT_W'(1) << (SH_W'(divQ) + SH_W'(2))) - CNT_W'(1);
    riseTick = busyQ && (cnt == lowMask);
    fallTick = busyQ && (cnt == fullMask);
    lastBit  = (bitIdx == BIT_W'(FRAME_W - 1));
    frame = {{PRE_W{1'b1}}, 2'b01, (strb.isRead ? 2'b10 : 2'b01),
             strb.phyAddr, strb.regNum, 2'b10,
             (strb.isRead ? {DATA_W{1'b1}} : strb.wrData)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      readQ   <= 1'b0;
      divQ    <= '0;
      cnt     <= '0;
      bitIdx  <= '0;
      txShift <= '1;
      rxShift <= '0;
      rdDone  <= 1'b0;
    end else begin
      rdDone <= 1'b0;
      if (strb.abort) begin
        busyQ <= 1'b0;
        cnt   <= '0;
      end else if (strb.start && !busyQ) begin
        busyQ   <= 1'b1;
        readQ   <= strb.isRead;
        divQ    <= strb.div;
        cnt     <= '0;
        bitIdx  <= '0;
        txShift <= frame;
      end else if (busyQ) begin
        if (fallTick) begin
          cnt <= '0;
          if (lastBit) begin
            busyQ  <= 1'b0;
            rdDone <= readQ;
          end else begin
            bitIdx  <= bitIdx + BIT_W'(1);
            txShift <= {txShift[FRAME_W-2:0], 1'b1};
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        if (riseTick && readQ && (bitIdx >= BIT_W'(DATA_POS)))
          rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      end
    end
  end

  always_comb begin
    mdc     = busyQ && (cnt > lowMask);
    mdioOut = txShift[FRAME_W-1];
    mdioOe  = busyQ && !(readQ && (bitIdx >= BIT_W'(TA_POS)));
    busy    = busyQ;
    rdData  = rxShift;
  end

  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && !busyQ && !strb.abort) |=> busyQ);
  a_r7_abort_idles: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (!busyQ && !mdioOe && !mdc));
  a_r9_released_before_done: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> !$past(mdioOe));
  a_r10_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && !$past(fallTick)) |-> $stable(mdioOut));
  a_r8_mdc_low_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !mdc);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrite,
  input  logic [SEL_W-1:0] busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  mdioStrobes_t      strb;
  logic              dpBusy, rdDone;
  logic [DATA_W-1:0] rdData;

  mdio_mgmt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb),
    .dpBusy(dpBusy), .rdDone(rdDone), .rdData(rdData)
  );

  mdio_mgmt_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .busy(dpBusy), .rdDone(rdDone), .rdData(rdData)
  );
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [15:0] respWord = 16'h0;

  logic [63:0] expFrame[$];
  int          expOeCnt[$];
  string       expTag[$];
  int          periodSeen = 0;
  int          r10Viol = 0;

  mdio_mgmt_master uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [63:0] mkFrame(input bit rd, input logic [4:0] phy,
                                          input logic [4:0] rn, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rn, 2'b10, d};
  endfunction

  task automatic setTarget(input logic [4:0] phy, input logic [4:0] rn);
    busWr(3'd2, {19'd0, phy, 3'd0, rn});
  endtask

  task automatic drvWrite(input string tag, input logic [4:0] phy,
                          input logic [4:0] rn, input logic [15:0] d);
    setTarget(phy, rn);
    expFrame.push_back(mkFrame(1'b0, phy, rn, d));
    expOeCnt.push_back(64);
    expTag.push_back(tag);
    busWr(3'd3, {16'hDEAD, d});
  endtask

  task automatic drvRead(input string tag, input logic [4:0] phy,
                         input logic [4:0] rn, input logic [15:0] d, input bit push);
    setTarget(phy, rn);
    respWord = d;
    if (push) begin
      expFrame.push_back(mkFrame(1'b1, phy, rn, d));
      expOeCnt.push_back(46);
      expTag.push_back(tag);
    end
    busWr(3'd1, 32'd0);
    busWr(3'd1, 32'd1);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      busRd(3'd5, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  // monitor, scoreboard and PHY responder
  initial begin
    logic prevMdc = 1'b0, prevOe = 1'b0, prevOut = 1'b1;
    int riseCnt = 0, oeCnt = 0, cyc = 0, lastRise = 0;
    logic [63:0] cap = '0;
    forever begin
      logic line;
      @(negedge clk);
      cyc++;
      line = mdioOe ? mdioOut : mdioIn;
      if (mdioOe && prevOe && (mdioOut !== prevOut) && !(prevMdc && !mdc))
        r10Viol++;
      if (mdioOe && !prevOe) begin
        riseCnt = 0; oeCnt = 0; cap = '0;
      end
      if (mdc && !prevMdc && riseCnt < 64) begin
        if (riseCnt > 0) periodSeen = cyc - lastRise;
        lastRise = cyc;
        cap[63-riseCnt] = line;
        if (mdioOe) oeCnt++;
        riseCnt++;
        if (riseCnt == 64) begin
          if (expFrame.size() == 0) begin
            check("R11", "unexpected frame", cap, 64'h0);
          end else begin
            logic [63:0] ef;
            int eo;
            string tg;
            ef = expFrame.pop_front();
            eo = expOeCnt.pop_front();
            tg = expTag.pop_front();
            check(tg, "frame bits", cap, ef);
            check("R9", "driven bit count", 64'(oeCnt), 64'(eo));
          end
        end
      end
      if (prevMdc && !mdc) begin
        if (riseCnt == 47) mdioIn = 1'b0;
        else if (riseCnt >= 48 && riseCnt < 64) mdioIn = respWord[63-riseCnt];
        else mdioIn = 1'b1;
      end
      prevMdc = mdc; prevOe = mdioOe; prevOut = mdioOut;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // reset state
    busRd(3'd5, v); check("R4", "reset indication", 64'(v), 64'h0);
    busRd(3'd0, v); check("R8", "reset divider", 64'(v), 64'h7);
    check("R7", "reset oe", 64'(mdioOe), 64'h0);
    check("R8", "reset mdc", 64'(mdc), 64'h0);
    rstN = 1'b1;
    busWr(3'd0, 32'd0);

    // R1 address fields
    setTarget(5'h13, 5'h02);
    busRd(3'd2, v); check("R1", "address readback", 64'(v), 64'h1302);

    // R2 write frame
    drvWrite("R2", 5'h13, 5'h02, 16'hA5C3);
    busRd(3'd5, v); check("R4", "busy after write", 64'(v), 64'h1);
    waitIdle();
    busRd(3'd5, v); check("R4", "idle after write", 64'(v), 64'h0);
    drvWrite("R2", 5'h1F, 5'h1F, 16'h0001);
    waitIdle();

    // R3/R5/R6 read
    drvRead("R3", 5'h01, 5'h0A, 16'h1234, 1'b1);
    busRd(3'd5, v); check("R5", "busy and not-valid", 64'(v), 64'h5);
    waitIdle();
    @(negedge clk);
    busRd(3'd5, v); check("R5", "flags clear after read", 64'(v), 64'h0);
    busRd(3'd4, v); check("R6", "status data", 64'(v), 64'h1234);
    busWr(3'd1, 32'd1);
    busRd(3'd5, v); check("R3", "no read without re-arm", 64'(v), 64'h0);
    drvRead("R9", 5'h1E, 5'h11, 16'hC0DE, 1'b1);
    waitIdle();
    @(negedge clk);
    busRd(3'd4, v); check("R6", "second status data", 64'(v), 64'hC0DE);

    // R11 ignored while busy
    drvWrite("R11", 5'h05, 5'h06, 16'h0F0F);
    repeat (20) @(negedge clk);
    busWr(3'd3, 32'h0000_FFFF);
    busWr(3'd1, 32'd0);
    busWr(3'd1, 32'd1);
    busRd(3'd3, v); check("R11", "data reg kept", 64'(v), 64'h0F0F);
    busRd(3'd5, v); check("R11", "no not-valid from edge", 64'(v), 64'h1);
    waitIdle();
    repeat (2) @(negedge clk);
    busRd(3'd5, v); check("R11", "no extra frame", 64'(v), 64'h0);

    // R8 divider period
    busWr(3'd0, 32'd2);
    drvWrite("R8", 5'h0C, 5'h03, 16'h5A5A);
    waitIdle();
    check("R8", "mdc period N=2", 64'(periodSeen), 64'd16);
    busWr(3'd0, 32'd0);
    drvWrite("R8", 5'h0D, 5'h04, 16'h6B6B);
    waitIdle();
    check("R8", "mdc period N=0", 64'(periodSeen), 64'd4);

    // R7 soft reset aborts a read
    drvRead("R7", 5'h02, 5'h03, 16'hBEEF, 1'b0);
    repeat (100) @(negedge clk);
    busRd(3'd5, v); check("R7", "busy before abort", 64'(v), 64'h5);
    busWr(3'd0, 32'h8000_0000);
    busRd(3'd5, v); check("R7", "flags after abort", 64'(v), 64'h0);
    check("R7", "oe after abort", 64'(mdioOe), 64'h0);
    check("R7", "mdc after abort", 64'(mdc), 64'h0);
    drvWrite("R7", 5'h08, 5'h09, 16'h3C3C);
    waitIdle();

    repeat (4) @(negedge clk);
    check("R10", "mid-phase changes", 64'(r10Viol), 64'h0);
    check("R2", "scoreboard drained", 64'(expFrame.size()), 64'h0);
    finishRun();
  end
endmodule